// File: doc/BRIEF.md
# Time-of-Day Hardware Clock

The block is a free-running time-of-day counter for a timing-aware network endpoint. On every clock cycle it adds a programmable increment, an integer-nanosecond part plus a 16-bit binary fraction of a nanosecond, to two timestamps kept side by side. The first is a 96-bit seconds-and-nanoseconds value whose nanosecond field wraps at one billion and carries into the seconds. The second is a 64-bit running nanosecond count that never wraps on seconds. A one-cycle pulse marks each seconds carry. A one-cycle step flag marks any cycle where a timestamp was written directly instead of advanced.

Software, or a servo outside this block, steers the clock through four valid-qualified inputs. Either timestamp can be overwritten, and the two writes are independent. The nominal increment can be replaced; the new value passes through a short register pipeline before it is used. A one-off offset correction adds a fixed extra amount to the increment for a set number of cycles, and a request that arrives while one is still running replaces it. A periodic drift correction adds a fixed amount once every `rate` cycles. All of these inputs are accepted in any cycle their strobe is high. None has a ready signal, so there is no back-pressure. A strobe held high for several cycles acts as that many requests.

Top module: `tod_clock`

## Requirements
- R1: While reset is held and after it, both timestamps read zero and `step`, `pps` and `adj_active` are low.
- R2: Each cycle without a load, both timestamps grow by the current increment. With defaults the increment is 6 ns + 0x6666/65536 ns (raw value 0x6_6666), applied from the first rising edge after reset is released.
- R3: `ts96` holds seconds in bits [95:48] and nanoseconds as fixed point in bits [47:0], with 16 fraction bits. When the nanosecond field would reach 1,000,000,000 ns, one billion is subtracted and the seconds field increments. Seconds × 10^9 × 65536 + bits [47:0] therefore equals `ts64` whenever both were loaded with the same value.
- R4: `pps` is high for exactly the one cycle in which the seconds field shows its increment. In that cycle the nanosecond remainder is less than one increment.
- R5: A load strobe at a rising edge makes the new value visible right after that edge. The 96-bit and 64-bit loads are independent: loading one leaves the other advancing normally.
- R6: `step` is high for exactly the one cycle after an edge at which either load strobe was high, and low otherwise.
- R7: After a period update sampled at edge E, the timestamps still advance by the old increment at edges E, E+1 and E+2, and by the new one from edge E+3 on (pipeline depth 2).
- R8: An offset request (ns, fns, count N) sampled at edge E adds its amount to the advance at edges E+2 through E+N+1. `adj_active` is high after edges E through E+N-1. A request with N = 0 has no effect and leaves `adj_active` low.
- R9: A new offset request while one is active discards the old remaining count. The old amount is still applied at the edge after the new request, and the new amount at the N following edges.
- R10: A drift request (ns, fns, rate R) sampled at edge E adds its amount to the advance at edges E+R+1, E+2R+1, and so on. A rate of 0 disables drift, which is the reset state.
- R11: Reset during operation clears any pending offset and drift and restores the default increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld96_valid | input | 1 | Load strobe for the 96-bit timestamp |
| ld96_value | input | 96 | Value for the 96-bit timestamp |
| ld64_valid | input | 1 | Load strobe for the 64-bit timestamp |
| ld64_value | input | 64 | Value for the 64-bit timestamp |
| per_valid | input | 1 | Period update strobe |
| per_ns | input | 4 | New period, integer ns |
| per_fns | input | 16 | New period, fractional ns |
| adj_valid | input | 1 | Offset request strobe |
| adj_ns | input | 4 | Offset amount per cycle, integer ns |
| adj_fns | input | 16 | Offset amount per cycle, fractional ns |
| adj_count | input | 16 | Number of cycles the offset is applied |
| adj_active | output | 1 | Offset correction still running |
| drift_valid | input | 1 | Drift request strobe |
| drift_ns | input | 4 | Drift amount, integer ns |
| drift_fns | input | 16 | Drift amount, fractional ns |
| drift_rate | input | 16 | Cycles between drift additions, 0 = off |
| ts96 | output | 96 | Seconds / nanoseconds timestamp |
| ts64 | output | 64 | Running nanosecond timestamp |
| step | output | 1 | Timestamp was loaded on the last edge |
| pps | output | 1 | Seconds field incremented on the last edge |

## Verification
Loads, `step`, `pps` and the seconds carry are due one edge after their cause. A period update lands three edges after it is sampled. An offset lands from the second edge through edge N+1, and a drift addition lands on edge R+1 and every R edges after that. The bench drives on falling edges and samples on the next falling edge. After a stimulus it checks `ts64` on every cycle against a running sum, with the increment for each edge chosen by those offsets. Each off-by-one in a latency therefore shows up as a wrong value in a named cycle, and the offset correction is also checked as a total over its whole window.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

  // Width of the increment sum: widest addend plus two carry bits.
  function automatic int inc_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m + 2;
  endfunction
endpackage

// File: rtl/tod_step_gen.sv
module tod_step_gen #(
  parameter int PER_NS_W     = 4,
  parameter int OFS_NS_W     = 4,
  parameter int DRF_NS_W     = 4,
  parameter int FNS_W        = 16,
  parameter int CNT_W        = 16,
  parameter int RATE_W       = 16,
  parameter int PER_LAT      = 2,
  parameter bit DRIFT_EN     = 1'b1,
  parameter int DEF_PER_NS   = 6,
  parameter int DEF_PER_FNS  = 'h6666,
  parameter int DEF_DRF_NS   = 0,
  parameter int DEF_DRF_FNS  = 0,
  parameter int DEF_DRF_RATE = 0,
  parameter int INC_W        = tod_pkg::inc_width(PER_NS_W + FNS_W, OFS_NS_W + FNS_W,
                                                  DRF_NS_W + FNS_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                per_valid,
  input  logic [PER_NS_W-1:0] per_ns,
  input  logic [FNS_W-1:0]    per_fns,
  input  logic                adj_valid,
  input  logic [OFS_NS_W-1:0] adj_ns,
  input  logic [FNS_W-1:0]    adj_fns,
  input  logic [CNT_W-1:0]    adj_count,
  input  logic                drift_valid,
  input  logic [DRF_NS_W-1:0] drift_ns,
  input  logic [FNS_W-1:0]    drift_fns,
  input  logic [RATE_W-1:0]   drift_rate,
  output logic [INC_W-1:0]    inc_o,
  output logic                adj_active_o
);
  localparam int PER_W = PER_NS_W + FNS_W;
  localparam int OFS_W = OFS_NS_W + FNS_W;
  localparam int DRF_W = DRF_NS_W + FNS_W;
  localparam logic [PER_W-1:0] DEF_PER = {PER_NS_W'(DEF_PER_NS), FNS_W'(DEF_PER_FNS)};

  // Period pipeline: stage 0 captures an update, later stages delay it.
  logic [PER_W-1:0] per_pipe [PER_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PER_LAT; i++) per_pipe[i] <= DEF_PER;
    end else begin
      if (per_valid) per_pipe[0] <= {per_ns, per_fns};
      for (int i = 1; i < PER_LAT; i++) per_pipe[i] <= per_pipe[i-1];
    end
  end

  // Offset correction: amount plus remaining cycle count.
  logic [OFS_W-1:0] adj_amt;
  logic [CNT_W-1:0] adj_cnt;
  logic [OFS_W-1:0] adj_add;

  always_ff @(posedge clk) begin
    if (rst) begin
      adj_amt <= '0;
      adj_cnt <= '0;
    end else if (adj_valid) begin
      adj_amt <= {adj_ns, adj_fns};
      adj_cnt <= adj_count;
    end else if (adj_cnt != '0) begin
      adj_cnt <= adj_cnt - CNT_W'(1);
    end
  end

  assign adj_add      = (adj_cnt != '0) ? adj_amt : '0;
  assign adj_active_o = (adj_cnt != '0);

  // Drift correction: optional, selected by parameter.
  logic [DRF_W-1:0] drf_add;

  if (DRIFT_EN) begin : g_drift
    logic [DRF_W-1:0]  drf_amt;
    logic [RATE_W-1:0] drf_rate;
    logic [RATE_W-1:0] drf_cnt;
    logic              drf_fire;

    assign drf_fire = (drf_rate != '0) && (drf_cnt == drf_rate - RATE_W'(1));

    always_ff @(posedge clk) begin
      if (rst) begin
        drf_amt  <= {DRF_NS_W'(DEF_DRF_NS), FNS_W'(DEF_DRF_FNS)};
        drf_rate <= RATE_W'(DEF_DRF_RATE);
        drf_cnt  <= '0;
      end else if (drift_valid) begin
        drf_amt  <= {drift_ns, drift_fns};
        drf_rate <= drift_rate;
        drf_cnt  <= '0;
      end else if (drf_rate == '0 || drf_fire) begin
        drf_cnt  <= '0;
      end else begin
        drf_cnt  <= drf_cnt + RATE_W'(1);
      end
    end

    assign drf_add = drf_fire ? drf_amt : '0;
  end else begin : g_no_drift
    assign drf_add = '0;
  end

  // Registered increment keeps the adders off the timestamp carry path.
  always_ff @(posedge clk) begin
    if (rst) inc_o <= INC_W'(DEF_PER);
    else     inc_o <= INC_W'(per_pipe[PER_LAT-1]) + INC_W'(adj_add) + INC_W'(drf_add);
  end
endmodule

// File: rtl/tod_acc96.sv
module tod_acc96 #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter int FNS_W = 16,
  parameter int INC_W = 22
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld_valid,
  input  logic [SEC_W+NS_W+FNS_W-1:0]   ld_value,
  input  logic [INC_W-1:0]              inc,
  output logic [SEC_W+NS_W+FNS_W-1:0]   ts,
  output logic                          pps
);
  localparam int NSF_W = NS_W + FNS_W;
  localparam logic [NSF_W:0] ROLL = (NSF_W+1)'(tod_pkg::NS_PER_SEC) << FNS_W;

  logic [SEC_W-1:0] sec_q;
  logic [NSF_W-1:0] ns_q;
  logic [NSF_W:0]   sum;
  logic             wrap;
  logic [NSF_W:0]   ns_nxt;

  assign sum    = {1'b0, ns_q} + (NSF_W+1)'(inc);
  assign wrap   = (sum >= ROLL);
  assign ns_nxt = wrap ? (sum - ROLL) : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      ns_q  <= '0;
      pps   <= 1'b0;
    end else if (ld_valid) begin
      sec_q <= ld_value[SEC_W+NSF_W-1:NSF_W];
      ns_q  <= ld_value[NSF_W-1:0];
      pps   <= 1'b0;
    end else begin
      sec_q <= sec_q + SEC_W'(wrap);
      ns_q  <= ns_nxt[NSF_W-1:0];
      pps   <= wrap;
    end
  end

  assign ts = {sec_q, ns_q};
endmodule

// File: rtl/tod_acc64.sv
module tod_acc64 #(
  parameter int TS_W  = 64,
  parameter int INC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [TS_W-1:0]  ld_value,
  input  logic [INC_W-1:0] inc,
  output logic [TS_W-1:0]  ts
);
  always_ff @(posedge clk) begin
    if (rst)           ts <= '0;
    else if (ld_valid) ts <= ld_value;
    else               ts <= ts + TS_W'(inc);
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int SEC_W        = 48,
  parameter int NS_W         = 32,
  parameter int FNS_W        = 16,
  parameter int TS64_W       = 64,
  parameter int PER_NS_W     = 4,
  parameter int OFS_NS_W     = 4,
  parameter int DRF_NS_W     = 4,
  parameter int CNT_W        = 16,
  parameter int RATE_W       = 16,
  parameter int PER_LAT      = 2,
  parameter bit DRIFT_EN     = 1'b1,
  parameter int DEF_PER_NS   = 6,
  parameter int DEF_PER_FNS  = 'h6666,
  parameter int DEF_DRF_NS   = 0,
  parameter int DEF_DRF_FNS  = 0,
  parameter int DEF_DRF_RATE = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld96_valid,
  input  logic [SEC_W+NS_W+FNS_W-1:0]   ld96_value,
  input  logic                          ld64_valid,
  input  logic [TS64_W-1:0]             ld64_value,
  input  logic                          per_valid,
  input  logic [PER_NS_W-1:0]           per_ns,
  input  logic [FNS_W-1:0]              per_fns,
  input  logic                          adj_valid,
  input  logic [OFS_NS_W-1:0]           adj_ns,
  input  logic [FNS_W-1:0]              adj_fns,
  input  logic [CNT_W-1:0]              adj_count,
  output logic                          adj_active,
  input  logic                          drift_valid,
  input  logic [DRF_NS_W-1:0]           drift_ns,
  input  logic [FNS_W-1:0]              drift_fns,
  input  logic [RATE_W-1:0]             drift_rate,
  output logic [SEC_W+NS_W+FNS_W-1:0]   ts96,
  output logic [TS64_W-1:0]             ts64,
  output logic                          step,
  output logic                          pps
);
  localparam int INC_W = tod_pkg::inc_width(PER_NS_W + FNS_W, OFS_NS_W + FNS_W,
                                            DRF_NS_W + FNS_W);

  logic [INC_W-1:0] inc;

  tod_step_gen #(
    .PER_NS_W(PER_NS_W), .OFS_NS_W(OFS_NS_W), .DRF_NS_W(DRF_NS_W), .FNS_W(FNS_W),
    .CNT_W(CNT_W), .RATE_W(RATE_W), .PER_LAT(PER_LAT), .DRIFT_EN(DRIFT_EN),
    .DEF_PER_NS(DEF_PER_NS), .DEF_PER_FNS(DEF_PER_FNS), .DEF_DRF_NS(DEF_DRF_NS),
    .DEF_DRF_FNS(DEF_DRF_FNS), .DEF_DRF_RATE(DEF_DRF_RATE), .INC_W(INC_W)
  ) step_gen_i (
    .clk(clk), .rst(rst),
    .per_valid(per_valid), .per_ns(per_ns), .per_fns(per_fns),
    .adj_valid(adj_valid), .adj_ns(adj_ns), .adj_fns(adj_fns), .adj_count(adj_count),
    .drift_valid(drift_valid), .drift_ns(drift_ns), .drift_fns(drift_fns),
    .drift_rate(drift_rate),
    .inc_o(inc), .adj_active_o(adj_active)
  );

  tod_acc96 #(.SEC_W(SEC_W), .NS_W(NS_W), .FNS_W(FNS_W), .INC_W(INC_W)) acc96_i (
    .clk(clk), .rst(rst), .ld_valid(ld96_valid), .ld_value(ld96_value),
    .inc(inc), .ts(ts96), .pps(pps)
  );

  tod_acc64 #(.TS_W(TS64_W), .INC_W(INC_W)) acc64_i (
    .clk(clk), .rst(rst), .ld_valid(ld64_valid), .ld_value(ld64_value),
    .inc(inc), .ts(ts64)
  );

  always_ff @(posedge clk) begin
    if (rst) step <= 1'b0;
    else     step <= ld96_valid | ld64_valid;
  end
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int FNS_W  = 16,
  parameter int TS64_W = 64,
  parameter int CNT_W  = 16,
  parameter int INC_W  = 22
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        ld96_valid,
  input logic [SEC_W+NS_W+FNS_W-1:0] ld96_value,
  input logic                        ld64_valid,
  input logic [TS64_W-1:0]           ld64_value,
  input logic                        adj_valid,
  input logic [CNT_W-1:0]            adj_count,
  input logic                        adj_active,
  input logic [SEC_W+NS_W+FNS_W-1:0] ts96,
  input logic [TS64_W-1:0]           ts64,
  input logic                        step,
  input logic                        pps
);
  localparam int NSF_W = NS_W + FNS_W;
  localparam logic [NSF_W-1:0] ROLL = NSF_W'(tod_pkg::NS_PER_SEC) << FNS_W;

  logic [SEC_W-1:0] sec_f;
  logic [NSF_W-1:0] ns_f;
  assign sec_f = ts96[SEC_W+NSF_W-1:NSF_W];
  assign ns_f  = ts96[NSF_W-1:0];

  // R5
  ld96_take_chk: assert property (@(posedge clk) disable iff (rst)
    ld96_valid |=> ts96 == $past(ld96_value));
  // R5
  ld64_take_chk: assert property (@(posedge clk) disable iff (rst)
    ld64_valid |=> ts64 == $past(ld64_value));
  // R6
  step_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ld96_valid || ld64_valid) |=> step);
  // R6
  step_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld96_valid || ld64_valid) |=> !step);
  // R4
  pps_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !ld96_valid |=> (pps == (sec_f == $past(sec_f) + SEC_W'(1))));
  // R4
  pps_remainder_chk: assert property (@(posedge clk) disable iff (rst)
    pps |-> ns_f < (NSF_W'(1) << INC_W));
  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_f < ROLL && !ld96_valid) |=> ns_f < ROLL);
  // R2
  ts64_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !ld64_valid |=> ts64 >= $past(ts64));
  // R8
  adj_start_chk: assert property (@(posedge clk) disable iff (rst)
    (adj_valid && adj_count != '0) |=> adj_active);
  // R8
  adj_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (adj_valid && adj_count == '0) |=> !adj_active);
endmodule

bind tod_clock tod_clock_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .FNS_W(FNS_W), .TS64_W(TS64_W), .CNT_W(CNT_W), .INC_W(INC_W)
) chk_i (
  .clk(clk), .rst(rst), .ld96_valid(ld96_valid), .ld96_value(ld96_value),
  .ld64_valid(ld64_valid), .ld64_value(ld64_value), .adj_valid(adj_valid),
  .adj_count(adj_count), .adj_active(adj_active), .ts96(ts96), .ts64(ts64),
  .step(step), .pps(pps)
);

// File: tb/tod_clock_tb_top.sv
`timescale 1ns/1ps
module tod_clock_tb_top;
  localparam logic [63:0] P0    = 64'h6_6666;
  localparam logic [63:0] P1    = 64'h6_6624;
  localparam logic [63:0] ROLLV = 64'd65_536_000_000_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic        ld96_valid = 1'b0;
  logic [95:0] ld96_value = '0;
  logic        ld64_valid = 1'b0;
  logic [63:0] ld64_value = '0;
  logic        per_valid = 1'b0;
  logic [3:0]  per_ns = '0;
  logic [15:0] per_fns = '0;
  logic        adj_valid = 1'b0;
  logic [3:0]  adj_ns = '0;
  logic [15:0] adj_fns = '0;
  logic [15:0] adj_count = '0;
  logic        drift_valid = 1'b0;
  logic [3:0]  drift_ns = '0;
  logic [15:0] drift_fns = '0;
  logic [15:0] drift_rate = '0;
  logic        adj_active;
  logic [95:0] ts96;
  logic [63:0] ts64;
  logic        step;
  logic        pps;

  int checks = 0;
  int fails  = 0;
  logic [63:0] expv;
  logic [63:0] base;
  logic [63:0] lval;

  always #10 clk = ~clk;

  tod_clock dut_i (
    .clk(clk), .rst(rst),
    .ld96_valid(ld96_valid), .ld96_value(ld96_value),
    .ld64_valid(ld64_valid), .ld64_value(ld64_value),
    .per_valid(per_valid), .per_ns(per_ns), .per_fns(per_fns),
    .adj_valid(adj_valid), .adj_ns(adj_ns), .adj_fns(adj_fns), .adj_count(adj_count),
    .adj_active(adj_active),
    .drift_valid(drift_valid), .drift_ns(drift_ns), .drift_fns(drift_fns),
    .drift_rate(drift_rate),
    .ts96(ts96), .ts64(ts64), .step(step), .pps(pps)
  );

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] total96(input logic [95:0] t);
    return t[95:48] * ROLLV + {16'd0, t[47:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ts96 in reset", ts96, 0);
    chk("R1 ts64 in reset", ts64, 0);
    chk("R1 step in reset", step, 0);
    chk("R1 pps in reset", pps, 0);
    chk("R1 adj_active in reset", adj_active, 0);
    rst = 1'b0;

    // R2: default increment from the first edge after reset
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      chk("R2 ts64 free run", ts64, 64'(k) * P0);
      chk("R2 ts96 free run", ts96, {32'd0, 64'(k) * P0});
    end

    // R5 R6 R3 R4: load both near a second boundary, run across the carry
    lval = 64'd999_990_000 << 16;
    ld96_value = {48'd0, lval[47:0]};
    ld64_value = lval;
    ld96_valid = 1'b1;
    ld64_valid = 1'b1;
    @(negedge clk);
    ld96_valid = 1'b0;
    ld64_valid = 1'b0;
    chk("R5 ts96 after load", ts96, {48'd0, lval[47:0]});
    chk("R5 ts64 after load", ts64, lval);
    chk("R6 step after load", step, 1);
    for (int k = 1; k <= 3000; k++) begin
      @(negedge clk);
      expv = lval + 64'(k) * P0;
      if (k == 1) chk("R6 step one cycle only", step, 0);
      chk("R2 ts64 after load", ts64, expv);
      chk("R3 seconds field", ts96[95:48], expv / ROLLV);
      chk("R3 nanosecond field", ts96[47:0], expv % ROLLV);
      chk("R4 pps on carry", pps, ((expv / ROLLV) != ((expv - P0) / ROLLV)));
      if (pps) chk("R4 remainder below one increment", (ts96[47:0] < 48'(P0)), 1);
    end
    chk("R3 one second reached", ts96[95:48], 1);

    // R5: 96-bit load alone, 64-bit keeps running
    base = ts64;
    ld96_value = {48'd7, 32'd999_999_990, 16'd0};
    ld96_valid = 1'b1;
    @(negedge clk);
    ld96_valid = 1'b0;
    chk("R5 ts96 loaded alone", ts96, {48'd7, 32'd999_999_990, 16'd0});
    chk("R5 ts64 undisturbed", ts64, base + P0);
    chk("R6 step on single load", step, 1);
    lval = total96({48'd7, 32'd999_999_990, 16'd0});
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      expv = lval + 64'(k) * P0;
      chk("R3 total of ts96", total96(ts96), expv);
      chk("R4 pps after single load", pps, ((expv / ROLLV) != ((expv - P0) / ROLLV)));
    end
    chk("R3 seconds after single load", ts96[95:48], 8);

    // R5: 64-bit load alone, 96-bit keeps running
    base = total96(ts96);
    ld64_value = 64'h1234_5678_9abc_0000;
    ld64_valid = 1'b1;
    @(negedge clk);
    ld64_valid = 1'b0;
    chk("R5 ts64 loaded alone", ts64, 64'h1234_5678_9abc_0000);
    chk("R5 ts96 undisturbed", total96(ts96), base + P0);
    chk("R6 step on 64-bit load", step, 1);

    // R7: period change latency
    base = ts64;
    per_ns = 4'd6;
    per_fns = 16'h6624;
    per_valid = 1'b1;
    expv = base;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 0) per_valid = 1'b0;
      expv = expv + ((k <= 2) ? P0 : P1);
      chk("R7 period pipeline", ts64, expv);
    end

    // R8: offset 64 fns over 1024 cycles
    base = ts64;
    adj_ns = 4'd0;
    adj_fns = 16'd64;
    adj_count = 16'd1024;
    adj_valid = 1'b1;
    expv = base;
    for (int k = 0; k <= 1029; k++) begin
      @(negedge clk);
      if (k == 0) adj_valid = 1'b0;
      expv = expv + P1 + ((k >= 2 && k <= 1025) ? 64'd64 : 64'd0);
      chk("R8 offset per cycle", ts64, expv);
      chk("R8 adj_active window", adj_active, (k <= 1023));
    end
    chk("R8 offset total one ns", ts64 - base - 64'd1030 * P1, 64'h1_0000);

    // R8: zero count does nothing
    base = ts64;
    adj_fns = 16'd500;
    adj_count = 16'd0;
    adj_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 0) adj_valid = 1'b0;
      chk("R8 zero count no effect", ts64, base + 64'(k + 1) * P1);
      chk("R8 zero count inactive", adj_active, 0);
    end

    // R9: replacement of a running offset
    base = ts64;
    adj_fns = 16'd3;
    adj_count = 16'd100;
    adj_valid = 1'b1;
    expv = base;
    for (int k = 0; k <= 60; k++) begin
      @(negedge clk);
      if (k == 0) adj_valid = 1'b0;
      expv = expv + P1 + ((k >= 2 && k <= 41) ? 64'd3 : ((k >= 42 && k <= 51) ? 64'd7 : 64'd0));
      chk("R9 replaced offset", ts64, expv);
      chk("R9 adj_active after replace", adj_active, (k <= 49));
      if (k == 39) begin
        adj_fns = 16'd7;
        adj_count = 16'd10;
        adj_valid = 1'b1;
      end
      if (k == 40) adj_valid = 1'b0;
    end

    // R10: drift 20 fns every 5 cycles
    base = ts64;
    drift_ns = 4'd0;
    drift_fns = 16'd20;
    drift_rate = 16'd5;
    drift_valid = 1'b1;
    expv = base;
    for (int k = 0; k <= 60; k++) begin
      @(negedge clk);
      if (k == 0) drift_valid = 1'b0;
      expv = expv + P1 + ((k >= 2 && ((k - 1) % 5) == 0) ? 64'd20 : 64'd0);
      chk("R10 drift cadence", ts64, expv);
    end
    drift_rate = 16'd0;
    drift_valid = 1'b1;
    @(negedge clk);
    drift_valid = 1'b0;
    repeat (2) @(negedge clk);
    base = ts64;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk("R10 rate zero disables drift", ts64, base + 64'(k) * P1);
    end

    // R11: reset mid-run with an offset pending
    adj_fns = 16'd9;
    adj_count = 16'd500;
    adj_valid = 1'b1;
    @(negedge clk);
    adj_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 ts64 cleared", ts64, 0);
    chk("R11 ts96 cleared", ts96, 0);
    chk("R11 adj_active cleared", adj_active, 0);
    rst = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R11 default increment restored", ts64, 64'(k) * P0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule